// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block connects two parallel buses, called the A side and the B side, and carries data across in both directions at once. Each direction has its own storage stage. That stage can work in one of three ways. It can pass data straight through as a transparent latch. It can keep a captured word as a held latch. Or it can act as an edge-triggered register gated by a clock enable. The mode is chosen at run time from that direction's latch-enable and clock-enable pins. Each direction also has its own strobe clock and its own active-low drive enable.

A three-state pin is split into two ports: a data-out bus and an active-high drive flag. A board-level tester can raise the test-mode input. While it is high, both sides stop normal operation. Each side's data and drive flag then come from boundary values supplied from outside, and both storage stages are frozen. Everything is sampled on one core clock. A direction strobe counts as a rising edge when the core clock sees it low on one edge and high on the next.

Each data input passes through a per-bit keeper that remembers the last 0 or 1 on that bit. In simulation, a floating or unknown bit is replaced by its kept value.

Each lane decodes one of four named modes every core cycle:

- PASS: latch enable high.
- HOLD: latch enable low and clock-enable pin high.
- CLOCK: latch enable low and clock-enable pin low.
- TEST: test mode high, which overrides the other three.

Any mode can move to any other at the next core edge, as the pins change. In PASS the stage loads the input on each edge. In CLOCK it loads only on a detected strobe rise. In HOLD and TEST it keeps its contents.

Top module: `bus_xcvr_dp`

## Requirements
- R1: With `ab_le` high and test mode low, `b_out` equals `a_in` in the same cycle, without waiting for a clock edge.
- R2: When `ab_le` goes low, the A-to-B stage keeps the value `a_in` had at the last core edge where `ab_le` was high.
- R3: With `ab_le` low and `ab_clk_en_n` high, `b_out` keeps its stored value across any activity on `ab_clk` and `a_in`.
- R4: With `ab_le` low and `ab_clk_en_n` low, the stage loads `a_in` at the first core edge that sees `ab_clk` high after seeing it low.
- R5: In the clocked mode, a falling `ab_clk`, or an `ab_clk` held steady at 0 or at 1, leaves the stored value unchanged.
- R6: Outside test mode, `b_drv` is the inverse of `ab_oe_n` and `a_drv` is the inverse of `ba_oe_n`. A drive flag of 0 means the pins are high-impedance.
- R7: The B-to-A direction behaves the same way, using `ba_le`, `ba_clk_en_n`, `ba_clk` and `ba_oe_n`. Its activity never changes the A-to-B stage, and the reverse also holds.
- R8: With `test_mode` high, `b_out`/`b_drv` equal `tst_b_data`/`tst_b_drive`, and `a_out`/`a_drv` equal `tst_a_data`/`tst_a_drive`.
- R9: While `test_mode` is high, both stages keep their contents regardless of their enables, clocks and inputs. When test mode is left in the held mode, the outputs show the words stored before entry.
- R10: After reset, both stages hold all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | A-side pin input |
| b_in | input | W | B-side pin input |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk_en_n | input | 1 | A-to-B clock enable, active low |
| ab_clk | input | 1 | A-to-B strobe |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk_en_n | input | 1 | B-to-A clock enable, active low |
| ba_clk | input | 1 | B-to-A strobe |
| test_mode | input | 1 | Boundary override of both sides |
| tst_a_data | input | W | A-side output value in test mode |
| tst_a_drive | input | 1 | A-side drive flag in test mode |
| tst_b_data | input | W | B-side output value in test mode |
| tst_b_drive | input | 1 | B-side drive flag in test mode |
| a_out | output | W | A-side pin output data |
| a_drv | output | 1 | A-side pin drive flag |
| b_out | output | W | B-side pin output data |
| b_drv | output | 1 | B-side pin drive flag |

## Verification
Each stage's contents reach the port whenever its lane is not in PASS or TEST. A wrong stored word therefore appears on `b_out` or `a_out` in the cycle right after the core edge that caused it. A wrong mode decode shows up at once as a missed or extra load. Examples are a load while in HOLD, a load on a falling strobe, or a PASS output that lags its input. The state frozen during test mode is hidden until the override drops. For that reason the stored words are compared on the first cycle after leaving test mode.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    typedef enum logic [1:0] {
        LM_PASS  = 2'd0,
        LM_HOLD  = 2'd1,
        LM_CLOCK = 2'd2,
        LM_TEST  = 2'd3
    } lane_mode_e;
endpackage

// File: rtl/bus_keeper.sv
module bus_keeper #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] data_eff
);
    logic [W-1:0] kept_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // known levels refresh the keeper; others leave it
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kept_q[i] <= 1'b0;
            end else if (pin_in[i] == 1'b0 || pin_in[i] == 1'b1) begin
                kept_q[i] <= pin_in[i];
            end
        end

        always_comb begin
            if (pin_in[i] == 1'b0 || pin_in[i] == 1'b1) begin
                data_eff[i] = pin_in[i];
            end else begin
                data_eff[i] = kept_q[i];
            end
        end
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import bus_xcvr_pkg::*;
#(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         clk_en_n,
    input  logic         strobe,
    input  logic         oe_n,
    input  logic         test_mode,
    input  logic [W-1:0] tst_data,
    input  logic         tst_drive,
    output logic [W-1:0] dout,
    output logic         drive
);
    lane_mode_e   mode;
    logic [W-1:0] store_q;
    logic         strobe_q;
    logic         strobe_rise;

    // mode decode, test override first
    always_comb begin
        if (test_mode)     mode = LM_TEST;
        else if (le)       mode = LM_PASS;
        else if (clk_en_n) mode = LM_HOLD;
        else               mode = LM_CLOCK;
    end

    assign strobe_rise = strobe & ~strobe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    // storage process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                LM_PASS:  store_q <= din;
                LM_CLOCK: if (strobe_rise) store_q <= din;
                LM_HOLD:  store_q <= store_q;
                LM_TEST:  store_q <= store_q;
                default:  store_q <= store_q;
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (mode)
            LM_TEST: begin
                dout  = tst_data;
                drive = tst_drive;
            end
            LM_PASS: begin
                dout  = din;
                drive = ~oe_n;
            end
            default: begin
                dout  = store_q;
                drive = ~oe_n;
            end
        endcase
    end
endmodule

// File: rtl/bus_xcvr_dp.sv
module bus_xcvr_dp #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_clk_en_n,
    input  logic         ab_clk,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_clk_en_n,
    input  logic         ba_clk,
    input  logic         test_mode,
    input  logic [W-1:0] tst_a_data,
    input  logic         tst_a_drive,
    input  logic [W-1:0] tst_b_data,
    input  logic         tst_b_drive,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);
    logic [W-1:0] a_kept;
    logic [W-1:0] b_kept;

    bus_keeper #(.W(W)) u_keep_a (.clk(clk), .rst_n(rst_n), .pin_in(a_in), .data_eff(a_kept));
    bus_keeper #(.W(W)) u_keep_b (.clk(clk), .rst_n(rst_n), .pin_in(b_in), .data_eff(b_kept));

    xcvr_lane #(.W(W)) u_lane_ab (
        .clk(clk), .rst_n(rst_n), .din(a_kept),
        .le(ab_le), .clk_en_n(ab_clk_en_n), .strobe(ab_clk), .oe_n(ab_oe_n),
        .test_mode(test_mode), .tst_data(tst_b_data), .tst_drive(tst_b_drive),
        .dout(b_out), .drive(b_drv)
    );

    xcvr_lane #(.W(W)) u_lane_ba (
        .clk(clk), .rst_n(rst_n), .din(b_kept),
        .le(ba_le), .clk_en_n(ba_clk_en_n), .strobe(ba_clk), .oe_n(ba_oe_n),
        .test_mode(test_mode), .tst_data(tst_a_data), .tst_drive(tst_a_drive),
        .dout(a_out), .drive(a_drv)
    );
endmodule

// File: rtl/bus_xcvr_dp_chk.sv
module bus_xcvr_dp_chk #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_clk_en_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         test_mode,
    input logic [W-1:0] tst_b_data,
    input logic         tst_b_drive,
    input logic [W-1:0] a_out,
    input logic         a_drv,
    input logic [W-1:0] b_out,
    input logic         b_drv
);
    p_pass_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_le && !test_mode) |-> (b_out == a_in));

    p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_clk_en_n && !test_mode) |=> (ab_le || test_mode || $stable(b_out)));

    p_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (b_drv == !ab_oe_n && a_drv == !ba_oe_n));

    p_pass_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_le && !test_mode) |-> (a_out == b_in));

    p_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (b_out == tst_b_data && b_drv == tst_b_drive));
endmodule

bind bus_xcvr_dp bus_xcvr_dp_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk_en_n(ab_clk_en_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .test_mode(test_mode),
    .tst_b_data(tst_b_data), .tst_b_drive(tst_b_drive),
    .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
);

// File: tb/test_bus_xcvr_dp.sv
`timescale 1ns/1ps
module test_bus_xcvr_dp;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_oe_n = 1'b0, ab_le = 1'b0, ab_clk_en_n = 1'b1, ab_clk = 1'b0;
    logic         ba_oe_n = 1'b0, ba_le = 1'b0, ba_clk_en_n = 1'b1, ba_clk = 1'b0;
    logic         test_mode = 1'b0;
    logic [W-1:0] tst_a_data = '0, tst_b_data = '0;
    logic         tst_a_drive = 1'b0, tst_b_drive = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_xcvr_dp #(.W(W)) i_bus_xcvr_dp (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk_en_n(ab_clk_en_n), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk_en_n(ba_clk_en_n), .ba_clk(ba_clk),
        .test_mode(test_mode), .tst_a_data(tst_a_data), .tst_a_drive(tst_a_drive),
        .tst_b_data(tst_b_data), .tst_b_drive(tst_b_drive),
        .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
    );

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // wait for the next edge, then settle before sampling
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // move to just after a falling edge to drive inputs
    task automatic to_drive();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        to_drive();
        rst_n = 1'b1;
        tick();
        chk(b_out, '0, "R10 b stage after reset");
        chk(a_out, '0, "R10 a stage after reset");
    endtask

    task automatic t_pass_and_latch_ab();
        to_drive();
        ab_le = 1'b1; a_in = 20'h1A2B3;
        #1 chk(b_out, 20'h1A2B3, "R1 transparent same cycle");
        tick();
        to_drive();
        a_in = 20'h5C0DE;
        #1 chk(b_out, 20'h5C0DE, "R1 transparent follows change");
        tick();
        to_drive();
        ab_le = 1'b0; ab_clk_en_n = 1'b1; a_in = 20'h77777;
        tick();
        chk(b_out, 20'h5C0DE, "R2 last transparent value kept");
    endtask

    task automatic t_hold_ab();
        for (int k = 0; k < 6; k++) begin
            to_drive();
            ab_clk = ~ab_clk;
            a_in = 20'h0F0F0 ^ W'(k);
            tick();
        end
        chk(b_out, 20'h5C0DE, "R3 held across strobe toggles");
    endtask

    task automatic t_clocked_ab();
        to_drive();
        ab_clk = 1'b0; ab_clk_en_n = 1'b0; a_in = 20'hAAAAA;
        tick();
        chk(b_out, 20'h5C0DE, "R5 low strobe no load");
        to_drive();
        ab_clk = 1'b1;
        tick();
        chk(b_out, 20'hAAAAA, "R4 load on strobe rise");
        to_drive();
        a_in = 20'h55555;
        tick();
        chk(b_out, 20'hAAAAA, "R5 static high no load");
        to_drive();
        ab_clk = 1'b0;
        tick();
        chk(b_out, 20'hAAAAA, "R5 falling strobe no load");
        to_drive();
        a_in = 20'h31337; ab_clk = 1'b1;
        tick();
        chk(b_out, 20'h31337, "R4 second rise loads");
        to_drive();
        ab_clk = 1'b0; ab_clk_en_n = 1'b1;
    endtask

    task automatic t_drive();
        to_drive();
        ab_oe_n = 1'b1; ba_oe_n = 1'b0;
        #1;
        chk(W'(b_drv), W'(0), "R6 b side released");
        chk(W'(a_drv), W'(1), "R6 a side driven");
        to_drive();
        ab_oe_n = 1'b0; ba_oe_n = 1'b1;
        #1;
        chk(W'(b_drv), W'(1), "R6 b side driven");
        chk(W'(a_drv), W'(0), "R6 a side released");
        to_drive();
        ba_oe_n = 1'b0;
    endtask

    task automatic t_mirror_ba();
        to_drive();
        ba_le = 1'b1; b_in = 20'hBEEF1;
        #1 chk(a_out, 20'hBEEF1, "R7 ba transparent");
        tick();
        to_drive();
        ba_le = 1'b0; ba_clk_en_n = 1'b0; ba_clk = 1'b0; b_in = 20'h12345;
        tick();
        to_drive();
        ba_clk = 1'b1;
        tick();
        chk(a_out, 20'h12345, "R7 ba load on rise");
        chk(b_out, 20'h31337, "R7 ab untouched by ba");
        to_drive();
        ba_clk = 1'b0; ba_clk_en_n = 1'b1;
    endtask

    task automatic t_test_mode();
        to_drive();
        test_mode = 1'b1;
        tst_b_data = 20'hC3C3C; tst_b_drive = 1'b0;
        tst_a_data = 20'h3C3C3; tst_a_drive = 1'b1;
        ab_oe_n = 1'b0; ba_oe_n = 1'b1;
        #1;
        chk(b_out, 20'hC3C3C, "R8 b data override");
        chk(W'(b_drv), W'(0), "R8 b drive override");
        chk(a_out, 20'h3C3C3, "R8 a data override");
        chk(W'(a_drv), W'(1), "R8 a drive override");
        ab_le = 1'b1; ba_le = 1'b1; a_in = 20'hDEAD0; b_in = 20'hFACE0;
        tick();
        to_drive();
        ab_le = 1'b0; ba_le = 1'b0; ab_clk_en_n = 1'b0; ba_clk_en_n = 1'b0;
        ab_clk = 1'b1; ba_clk = 1'b1;
        tick();
        to_drive();
        test_mode = 1'b0; ab_clk_en_n = 1'b1; ba_clk_en_n = 1'b1; ba_oe_n = 1'b0;
        #1;
        chk(b_out, 20'h31337, "R9 ab word restored");
        chk(a_out, 20'h12345, "R9 ba word restored");
    endtask

    initial begin
        t_reset();
        t_pass_and_latch_ab();
        t_hold_ab();
        t_clocked_ab();
        t_drive();
        t_mirror_ba();
        t_test_mode();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule